// File: doc/BRIEF.md
# Banked Virtual Address Translator

This block turns a 12-bit word address from a small virtual space into the place where the word actually lives. Every address goes to exactly one of four targets:

- a hardware-register slot in the lowest few words;
- a physical RAM word, either in a fixed region or through a 256-word window steered by a 3-bit RAM bank register;
- a physical ROM word, either in a fixed region or through a 1024-word window steered by a 6-bit ROM bank register;
- an error.

Both bank registers live behind the register window. A write request aimed at the right register slot updates them, and the new value applies to the very next accepted request.

Requests come in on a valid/ready stream: address, a write flag and a 15-bit data word. Each accepted request yields one translated result on an output valid/ready stream, which carries the target code, the physical address, the register index, and the write flag and data passed through. A single register stage separates the two streams.

A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or the consumer takes the current result in that same cycle. While `out_valid` is high and `out_ready` is low, the result stays unchanged and no new request is taken.

Target codes are: register = 0, RAM = 1, ROM = 2, error = 3. The physical address is zero for the register and error targets.

Top module: `vaddr_xlate`

## Requirements
- R1: Addresses 0 to 6 give target 0, a register index equal to the address, and physical address 0.
- R2: Addresses 7 to 767 give target 1 with a physical address equal to the virtual address.
- R3: Addresses 768 to 1023 give target 1 with physical address RAM bank × 256 + (address mod 256).
- R4: A read of addresses 1024 to 2047 with a ROM bank below 36 gives target 2 with physical address ROM bank × 1024 + (address mod 1024).
- R5: A read of addresses 1024 to 2047 while the ROM bank is 36 or more gives target 3 and physical address 0.
- R6: A read of addresses 2048 to 4095 gives target 2 with a physical address equal to the virtual address, whatever the ROM bank holds.
- R7: A write to any address of 1024 or above gives target 3 and physical address 0, and changes no bank register.
- R8: The bank registers are written only by an accepted write request to a register slot. Slot 3 loads the RAM bank from data bits [2:0]. Slot 4 loads the ROM bank from data bits [5:0]. Slot 5 loads the RAM bank from bits [2:0] and the ROM bank from bits [8:3]. Writes to other slots and all reads leave both bank registers unchanged. A new bank value applies from the next accepted request onward.
- R9: Reset clears both bank registers to zero and leaves no result pending.
- R10: `in_ready` equals (not `out_valid`) or `out_ready`. A pending result holds all of its fields while `out_ready` is low. Each accepted request produces one result in the following cycle.
- R11: The write flag and data of each request appear unchanged with its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_addr | input | 12 | Virtual word address |
| in_write | input | 1 | Request is a write |
| in_wdata | input | 15 | Write data word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_target | output | 2 | Target code: 0 register, 1 RAM, 2 ROM, 3 error |
| out_paddr | output | 16 | Physical RAM or ROM word address |
| out_regidx | output | 3 | Register slot index |
| out_write | output | 1 | Write flag of the request |
| out_wdata | output | 15 | Data word of the request |

## Verification
The case that is hardest to reach from the ports is a bank-register write followed at once by a banked-window access, while the output stream is stalled. In that case the second request must wait, and it must then use the new bank value rather than the one in force when it first appeared.

The stimulus produces this case in two ways:

- A directed phase lowers `out_ready` around back-to-back bank-write and window-access pairs.
- A long randomized phase mixes frequent bank writes, ROM bank values beyond 35, ROM writes and random back-pressure.

Throughout, every cycle is compared against a behavioural model.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W   = 12;
  localparam int DATA_W = 15;
  localparam int RIDX_W = 3;
  localparam int PA_W   = 16;

  typedef enum logic [1:0] {
    TGT_REG = 2'd0,
    TGT_RAM = 2'd1,
    TGT_ROM = 2'd2,
    TGT_ERR = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e              tgt;
    logic [PA_W-1:0]   paddr;
    logic [RIDX_W-1:0] ridx;
    logic              wr;
    logic [DATA_W-1:0] wdata;
  } xres_t;
endpackage

// File: rtl/xlate_decode.sv
module xlate_decode
  import xlate_pkg::*;
#(
  parameter int REG_COUNT  = 7,
  parameter int RAM_FIXED  = 768,
  parameter int RAM_WIN_W  = 8,
  parameter int RAM_BANK_W = 3,
  parameter int ROM_WIN_W  = 10,
  parameter int ROM_BANK_W = 6,
  parameter int ROM_BANKS  = 36
) (
  input  logic [VA_W-1:0]       vaddr,
  input  logic                  write,
  input  logic [RAM_BANK_W-1:0] ram_bank,
  input  logic [ROM_BANK_W-1:0] rom_bank,
  output tgt_e                  tgt,
  output logic [PA_W-1:0]       paddr,
  output logic [RIDX_W-1:0]     ridx
);
  localparam int RAM_WORDS = 1 << (RAM_WIN_W + 2);
  localparam int ROM_BTOP  = RAM_WORDS + (1 << ROM_WIN_W);

  localparam logic [VA_W-1:0]       REG_LIM = VA_W'(REG_COUNT);
  localparam logic [VA_W-1:0]       RAM_FIX = VA_W'(RAM_FIXED);
  localparam logic [VA_W-1:0]       RAM_TOP = VA_W'(RAM_WORDS);
  localparam logic [VA_W-1:0]       ROM_TOP = VA_W'(ROM_BTOP);
  localparam logic [ROM_BANK_W-1:0] ROM_LIM = ROM_BANK_W'(ROM_BANKS);

  always_comb begin
    tgt   = TGT_ERR;
    paddr = '0;
    ridx  = '0;
    if (vaddr < REG_LIM) begin
      tgt  = TGT_REG;
      ridx = vaddr[RIDX_W-1:0];
    end else if (vaddr < RAM_TOP) begin
      tgt = TGT_RAM;
      if (vaddr >= RAM_FIX)
        paddr = PA_W'({ram_bank, vaddr[RAM_WIN_W-1:0]});
      else
        paddr = PA_W'(vaddr);
    end else if (write) begin
      tgt = TGT_ERR;
    end else if (vaddr < ROM_TOP) begin
      if (rom_bank < ROM_LIM) begin
        tgt   = TGT_ROM;
        paddr = PA_W'({rom_bank, vaddr[ROM_WIN_W-1:0]});
      end
    end else begin
      tgt   = TGT_ROM;
      paddr = PA_W'(vaddr);
    end
  end
endmodule

// File: rtl/xlate_banks.sv
module xlate_banks
  import xlate_pkg::*;
#(
  parameter int RAM_BANK_W = 3,
  parameter int ROM_BANK_W = 6,
  parameter int RAM_IDX    = 3,
  parameter int ROM_IDX    = 4,
  parameter int BOTH_IDX   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [RIDX_W-1:0]     ridx,
  input  logic [DATA_W-1:0]     wdata,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic [ROM_BANK_W-1:0] rom_bank
);
  localparam logic [RIDX_W-1:0] I_RAM  = RIDX_W'(RAM_IDX);
  localparam logic [RIDX_W-1:0] I_ROM  = RIDX_W'(ROM_IDX);
  localparam logic [RIDX_W-1:0] I_BOTH = RIDX_W'(BOTH_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_bank <= '0;
      rom_bank <= '0;
    end else if (wr_en) begin
      case (ridx)
        I_RAM: ram_bank <= wdata[RAM_BANK_W-1:0];
        I_ROM: rom_bank <= wdata[ROM_BANK_W-1:0];
        I_BOTH: begin
          ram_bank <= wdata[RAM_BANK_W-1:0];
          rom_bank <= wdata[RAM_BANK_W +: ROM_BANK_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xlate_stage.sv
module xlate_stage
  import xlate_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  up_valid,
  output logic  up_ready,
  input  xres_t up_data,
  output logic  dn_valid,
  input  logic  dn_ready,
  output xres_t dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end
endmodule

// File: rtl/vaddr_xlate.sv
module vaddr_xlate
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VA_W-1:0]   in_addr,
  input  logic              in_write,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_target,
  output logic [PA_W-1:0]   out_paddr,
  output logic [RIDX_W-1:0] out_regidx,
  output logic              out_write,
  output logic [DATA_W-1:0] out_wdata
);
  localparam int RAM_BANK_W = 3;
  localparam int ROM_BANK_W = PA_W - 10;

  logic [RAM_BANK_W-1:0] ram_bank;
  logic [ROM_BANK_W-1:0] rom_bank;
  tgt_e                  d_tgt;
  logic [PA_W-1:0]       d_paddr;
  logic [RIDX_W-1:0]     d_ridx;
  xres_t                 st_in;
  xres_t                 st_out;
  logic                  bank_we;

  xlate_decode #(
    .RAM_BANK_W (RAM_BANK_W),
    .ROM_BANK_W (ROM_BANK_W)
  ) u_dec (
    .vaddr    (in_addr),
    .write    (in_write),
    .ram_bank (ram_bank),
    .rom_bank (rom_bank),
    .tgt      (d_tgt),
    .paddr    (d_paddr),
    .ridx     (d_ridx)
  );

  assign bank_we = in_valid && in_ready && in_write && (d_tgt == TGT_REG);

  xlate_banks #(
    .RAM_BANK_W (RAM_BANK_W),
    .ROM_BANK_W (ROM_BANK_W)
  ) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bank_we),
    .ridx     (d_ridx),
    .wdata    (in_wdata),
    .ram_bank (ram_bank),
    .rom_bank (rom_bank)
  );

  always_comb begin
    st_in.tgt   = d_tgt;
    st_in.paddr = d_paddr;
    st_in.ridx  = d_ridx;
    st_in.wr    = in_write;
    st_in.wdata = in_wdata;
  end

  xlate_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (st_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (st_out)
  );

  assign out_target = st_out.tgt;
  assign out_paddr  = st_out.paddr;
  assign out_regidx = st_out.ridx;
  assign out_write  = st_out.wr;
  assign out_wdata  = st_out.wdata;
endmodule

// File: rtl/xlate_check.sv
module xlate_check (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [11:0] in_addr,
  input logic        in_write,
  input logic [14:0] in_wdata,
  input logic        out_valid,
  input logic        out_ready,
  input logic [1:0]  out_target,
  input logic [15:0] out_paddr,
  input logic [2:0]  out_regidx,
  input logic        out_write,
  input logic [14:0] out_wdata
);
  localparam logic [15:0] ROM_SIZE = 16'(36 * 1024);

  logic acc;
  assign acc = in_valid && in_ready;

  p_idle_after_reset_r9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_paddr)
      && $stable(out_target) && $stable(out_regidx) && $stable(out_wdata));

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_reg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_addr < 12'd7 |=> out_target == 2'd0 && out_regidx == $past(in_addr[2:0]));

  p_fixed_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_addr >= 12'd7 && in_addr < 12'd768 |=>
      out_target == 2'd1 && out_paddr == {4'd0, $past(in_addr)});

  p_fixed_rom_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_write && in_addr >= 12'd2048 |=>
      out_target == 2'd2 && out_paddr == {4'd0, $past(in_addr)});

  p_rom_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_write && in_addr >= 12'd1024 |=> out_target == 2'd3 && out_paddr == 16'd0);

  p_rom_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_target == 2'd2 |-> out_paddr < ROM_SIZE);

  p_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_write == $past(in_write) && out_wdata == $past(in_wdata));
endmodule

bind vaddr_xlate xlate_check u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_addr    (in_addr),
  .in_write   (in_write),
  .in_wdata   (in_wdata),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_target (out_target),
  .out_paddr  (out_paddr),
  .out_regidx (out_regidx),
  .out_write  (out_write),
  .out_wdata  (out_wdata)
);

// File: tb/sim_vaddr_xlate.sv
`timescale 1ns/1ps
module sim_vaddr_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_addr = '0;
  logic        in_write = 1'b0;
  logic [14:0] in_wdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_target;
  logic [15:0] out_paddr;
  logic [2:0]  out_regidx;
  logic        out_write;
  logic [14:0] out_wdata;

  always #10 clk = ~clk;

  vaddr_xlate u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_write(in_write), .in_wdata(in_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_target(out_target),
    .out_paddr(out_paddr), .out_regidx(out_regidx), .out_write(out_write),
    .out_wdata(out_wdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model state
  int    m_ram = 0;
  int    m_rom = 0;
  bit    m_valid = 0;
  int    m_tgt = 0;
  int    m_pa = 0;
  int    m_ri = 0;
  bit    m_wr = 0;
  int    m_wd = 0;
  string m_tag = "R9";

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_xlate(input int a, input bit w, output int t, output int pa,
                             output int ri, output string tag);
    t = 3; pa = 0; ri = 0;
    if (a <= 6) begin
      t = 0; ri = a;
      tag = (w && a >= 3 && a <= 5) ? "R8" : "R1";
    end else if (a < 768) begin
      t = 1; pa = a; tag = "R2";
    end else if (a < 1024) begin
      t = 1; pa = m_ram * 256 + (a % 256); tag = "R3";
    end else if (w) begin
      tag = "R7";
    end else if (a < 2048) begin
      if (m_rom < 36) begin t = 2; pa = m_rom * 1024 + (a % 1024); tag = "R4"; end
      else tag = "R5";
    end else begin
      t = 2; pa = a; tag = "R6";
    end
  endtask

  task automatic step(bit v, int a, bit w, int d, bit r);
    int t, pa, ri;
    string tag;
    bit exp_rdy;
    in_valid = v; in_addr = a[11:0]; in_write = w; in_wdata = d[14:0]; out_ready = r;
    #1;
    exp_rdy = !m_valid || r;
    check("R10", "in_ready", int'(in_ready), int'(exp_rdy));
    if (v && exp_rdy) begin
      model_xlate(a, w, t, pa, ri, tag);
      m_valid = 1; m_tgt = t; m_pa = pa; m_ri = ri; m_wr = w; m_wd = d % 32768; m_tag = tag;
      if (w && a == 3) m_ram = d % 8;
      if (w && a == 4) m_rom = d % 64;
      if (w && a == 5) begin m_ram = d % 8; m_rom = (d / 8) % 64; end
    end else if (r) begin
      m_valid = 0;
    end
    @(negedge clk);
    check(m_tag, "out_valid", int'(out_valid), int'(m_valid));
    if (m_valid && out_valid) begin
      check(m_tag, "out_target", int'(out_target), m_tgt);
      check(m_tag, "out_paddr", int'(out_paddr), m_pa);
      check(m_tag, "out_regidx", int'(out_regidx), m_ri);
      check("R11", "out_write", int'(out_write), int'(m_wr));
      check("R11", "out_wdata", int'(out_wdata), m_wd);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R9", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    // R9: banks zero after reset, seen through both banked windows
    step(1, 900, 0, 0, 1);
    step(1, 1100, 0, 0, 1);
    // R1 register slots
    for (int a = 0; a <= 6; a++) step(1, a, 0, 0, 1);
    // R2 fixed RAM edges
    step(1, 7, 0, 0, 1); step(1, 500, 1, 123, 1); step(1, 767, 0, 0, 1);
    // R3 / R8 every RAM bank via slot 3
    for (int b = 0; b < 8; b++) begin
      step(1, 3, 1, b, 1);
      step(1, 768, 0, 0, 1);
      step(1, 1023, 0, 0, 1);
    end
    // R4 / R5 ROM banks via slot 4, including limits
    for (int b = 0; b < 64; b += 7) begin
      step(1, 4, 1, b, 1); step(1, 1024, 0, 0, 1); step(1, 2047, 0, 0, 1);
    end
    step(1, 4, 1, 35, 1); step(1, 1500, 0, 0, 1);
    step(1, 4, 1, 36, 1); step(1, 1500, 0, 0, 1);
    step(1, 4, 1, 63, 1); step(1, 1024, 0, 0, 1);
    // R6 fixed ROM unaffected by a bad bank
    step(1, 2048, 0, 0, 1); step(1, 4095, 0, 0, 1);
    // R8 combined slot, and writes to other slots ignored
    step(1, 5, 1, (20 << 3) | 6, 1); step(1, 800, 0, 0, 1); step(1, 1030, 0, 0, 1);
    step(1, 0, 1, 7, 1); step(1, 6, 1, 0, 1); step(1, 3, 0, 0, 1);
    step(1, 800, 0, 0, 1); step(1, 1030, 0, 0, 1);
    // R7 ROM writes flagged and ignored
    step(1, 1500, 1, 5, 1); step(1, 3000, 1, 9, 1);
    step(1, 800, 0, 0, 1); step(1, 1030, 0, 0, 1);
    // R10 back-pressure around bank write + banked access
    step(1, 3, 1, 2, 0); step(1, 900, 0, 0, 0); step(1, 900, 0, 0, 0);
    step(1, 900, 0, 0, 1); step(1, 900, 0, 0, 1); step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1);
    // randomized mix
    for (int i = 0; i < 4000; i++) begin
      int sel, a, d;
      sel = int'($urandom_range(0, 9));
      d = int'($urandom_range(0, 32767));
      case (sel)
        0, 1: a = int'($urandom_range(3, 5));
        2:    a = int'($urandom_range(0, 6));
        3, 4: a = int'($urandom_range(768, 1023));
        5, 6: a = int'($urandom_range(1024, 2047));
        default: a = int'($urandom_range(0, 4095));
      endcase
      step($urandom_range(0, 3) != 0, a, (sel <= 1) || ($urandom_range(0, 5) == 0), d,
           $urandom_range(0, 2) != 0);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule